// File: doc/BRIEF.md
# Flash Command Interface State Machine

This block is the command decoder on the device side of a parallel NOR-style flash memory. It samples the bus pins (chip enable, write enable, output enable, address, data) on its own clock. It spots the start and end of every write cycle and walks the multi-write unlock sequences that select an operating mode. Three modes exist: array reads, identifier reads, and a program setup that accepts one address and data write.

Reads return either array words or identifier words, depending on the mode. The identifier words are a manufacturer code, a device code and a per-sector protect flag. A program request goes to a separate program engine. For a fixed number of cycles that engine holds the ready line low and serves status words to reads, then it clears bits in the array cell. While it runs, the command path ignores bus writes.

An active-low hardware reset pin that stays low long enough aborts all activity and restores array mode. Reads remain blocked for a short delay after the pin is released. The storage is a small register array that comes up erased.

Top module: `flash_cmd_if`

## Requirements
- R1: After power-on reset the block is in array mode, `ready` is 1, every array word reads FFFFh, and a write that is not part of an unlock sequence changes no word.
- R2: The current mode persists across any number of reads, until a complete command sequence selects a different mode.
- R3: Identifier mode is entered by writing AAh (low data byte) to address bits [10:0]=555h, then 55h to 2AAh, then 90h to any address. In that mode, address bits [7:0]=00h read the manufacturer code (default 0052h) and 01h read the device code (default 3A91h).
- R4: In identifier mode, offset 02h reads the protect flag on bit 0 (1 = protected) of the sector given by address bits [18:12], with all other bits 0. The default map protects sectors 0 and 2 only. All other offsets read 0000h.
- R5: The two unlock writes followed by F0h leave identifier mode and return to array mode.
- R6: The two unlock writes, then A0h, then one write of address and data, program the array word at address bits [5:0]. Once the operation completes, that word holds the old value AND the written data.
- R7: From the end of the program data write until the operation completes (PROG_CYCLES cycles), `ready` is 0. During that time a read returns a status word: bit 7 is the inverse of bit 7 of the program data, bit 6 starts at 0 and flips on every new read, and all other bits are 0.
- R8: Bus writes made while a program operation runs are ignored: they neither advance the sequencer nor change the mode.
- R9: A wrong address or data value in either unlock write returns the sequencer to idle and leaves the mode unchanged.
- R10: A write's address is taken in the first cycle in which both chip enable and write enable are low. Its data is taken in the last such cycle.
- R11: If `hwResetN` stays low for RST_HOLD cycles, the block aborts any program operation without writing, returns to array mode and holds `ready` at 0. After release, reads keep `dataOe` at 0 and `dataOut` at 0 for RD_DELAY cycles. A shorter low pulse has no effect.
- R12: `dataOe` is 1 only while chip enable and output enable are both low. Otherwise `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all pins sampled on its rising edge |
| porN | input | 1 | Active-low power-on reset, asynchronous |
| hwResetN | input | 1 | Active-low hardware reset pin |
| ceN | input | 1 | Active-low chip enable |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| addr | input | ADDR_W | Word address |
| dataIn | input | DATA_W | Write data bus |
| dataOut | output | DATA_W | Read data (0 when not driven) |
| dataOe | output | 1 | Read data valid / output drive enable |
| ready | output | 1 | 1 when no program operation or reset is in progress |

## Verification
A sequencer that is stuck or mis-stepped shows up on the next read: an identifier code appears where array data belongs, or the reverse, one or two cycles after the read starts. A program engine that is wrongly busy or idle shows at `ready` as soon as the program data write ends, and later as a wrong array word. A wrong bit-clear rule also shows as a wrong array word. A failed abort or a failed read block after a hardware reset shows on `dataOe` on the first read after release, and on the mode seen by the reads that follow.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_UNL1,
    SEQ_UNL2,
    SEQ_PGM
  } seqState_t;

  typedef struct packed {
    logic progLaunch;
    logic modeId;
    logic readBlock;
    logic abort;
  } ctrlStrobe_t;

  localparam int            CMD_AW     = 11;
  localparam logic [10:0]   UNLOCK_A1  = 11'h555;
  localparam logic [10:0]   UNLOCK_A2  = 11'h2AA;
  localparam logic [7:0]    CMD_UNL1   = 8'hAA;
  localparam logic [7:0]    CMD_UNL2   = 8'h55;
  localparam logic [7:0]    CMD_IDENT  = 8'h90;
  localparam logic [7:0]    CMD_PROG   = 8'hA0;
  localparam logic [7:0]    CMD_ARRAY  = 8'hF0;

endpackage

// File: rtl/flash_cmd_ctrl.sv
module flash_cmd_ctrl
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int RST_HOLD = 8,
  parameter int RD_DELAY = 8
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              hwResetN,
  input  logic              wrDone,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              progBusy,
  output ctrlStrobe_t       strb
);

  localparam int HOLD_W = $clog2(RST_HOLD + 1);
  localparam int DLY_W  = $clog2(RD_DELAY + 1);

  logic              rstQ;
  logic [HOLD_W-1:0] holdCnt;
  logic [DLY_W-1:0]  dlyCnt;
  seqState_t         seq, seqNext;
  logic              modeId, modeNext;
  logic              inReset, readBlock, cmdOk, launch;
  logic [10:0]       cmdAddr;
  logic [7:0]        cmdByte;
  logic              unusedBits;

  assign cmdAddr    = wrAddr[CMD_AW-1:0];
  assign cmdByte    = wrData[7:0];
  assign unusedBits = ^{wrAddr, wrData};

  assign inReset   = (holdCnt == HOLD_W'(RST_HOLD));
  assign readBlock = inReset || (dlyCnt != '0);
  assign cmdOk     = wrDone && !progBusy && !readBlock;

  always_comb begin
    seqNext  = seq;
    modeNext = modeId;
    launch   = 1'b0;
    if (cmdOk) begin
      unique case (seq)
        SEQ_IDLE: seqNext = (cmdAddr == UNLOCK_A1 && cmdByte == CMD_UNL1) ? SEQ_UNL1 : SEQ_IDLE;
        SEQ_UNL1: seqNext = (cmdAddr == UNLOCK_A2 && cmdByte == CMD_UNL2) ? SEQ_UNL2 : SEQ_IDLE;
        SEQ_UNL2: begin
          seqNext = SEQ_IDLE;
          if (cmdByte == CMD_IDENT)      modeNext = 1'b1;
          else if (cmdByte == CMD_ARRAY) modeNext = 1'b0;
          else if (cmdByte == CMD_PROG)  seqNext  = SEQ_PGM;
        end
        SEQ_PGM: begin
          seqNext = SEQ_IDLE;
          launch  = 1'b1;
        end
        default: seqNext = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstQ    <= 1'b1;
      holdCnt <= '0;
      dlyCnt  <= '0;
      seq     <= SEQ_IDLE;
      modeId  <= 1'b0;
    end else begin
      rstQ <= hwResetN;
      if (!rstQ) begin
        if (!inReset) holdCnt <= holdCnt + 1'b1;
      end else begin
        holdCnt <= '0;
        if (inReset)             dlyCnt <= DLY_W'(RD_DELAY);
        else if (dlyCnt != '0)   dlyCnt <= dlyCnt - 1'b1;
      end
      if (inReset) begin
        seq    <= SEQ_IDLE;
        modeId <= 1'b0;
      end else begin
        seq    <= seqNext;
        modeId <= modeNext;
      end
    end
  end

  always_comb begin
    strb.progLaunch = launch;
    strb.modeId     = modeId;
    strb.readBlock  = readBlock;
    strb.abort      = inReset;
  end

endmodule

// File: rtl/flash_cmd_dp.sv
module flash_cmd_dp
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W   = 19,
  parameter int DATA_W   = 16,
  parameter int MEM_AW   = 6,
  parameter int SECT_LSB = 12,
  parameter int SECT_W   = 7,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0052,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h3A91,
  parameter logic [(1<<SECT_W)-1:0] PROT_MAP = 'h5
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  ctrlStrobe_t       strb,
  input  logic              progBusy,
  input  logic              progBit7,
  input  logic              memWe,
  input  logic [MEM_AW-1:0] memWaddr,
  input  logic [DATA_W-1:0] memWdata,
  output logic              wrDone,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << MEM_AW;

  logic              ceQ, weQ, oeQ;
  logic [ADDR_W-1:0] addrQ, addrLat;
  logic [DATA_W-1:0] dataQ, dataLat;
  logic              wrActD, rdActD, togBit;
  logic              wrAct, wrStart, rdAct, rdStart;
  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] rdVal;
  logic [7:0]        idOff;
  logic [SECT_W-1:0] sect;
  logic              unusedAddr;

  assign wrAct   = !ceQ && !weQ;
  assign wrStart = wrAct && !wrActD;
  assign wrDone  = !wrAct && wrActD;
  assign rdAct   = !ceQ && !oeQ;
  assign rdStart = rdAct && !rdActD;
  assign wrAddr  = addrLat;
  assign wrData  = dataLat;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      ceQ     <= 1'b1;
      weQ     <= 1'b1;
      oeQ     <= 1'b1;
      addrQ   <= '0;
      dataQ   <= '0;
      wrActD  <= 1'b0;
      rdActD  <= 1'b0;
      addrLat <= '0;
      dataLat <= '0;
      togBit  <= 1'b0;
    end else begin
      ceQ    <= ceN;
      weQ    <= weN;
      oeQ    <= oeN;
      addrQ  <= addr;
      dataQ  <= dataIn;
      wrActD <= wrAct;
      rdActD <= rdAct;
      if (wrStart) addrLat <= addrQ;
      if (wrAct)   dataLat <= dataQ;
      if (!progBusy)    togBit <= 1'b0;
      else if (rdStart) togBit <= !togBit;
    end
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (memWe) begin
      mem[memWaddr] <= mem[memWaddr] & memWdata;
    end
  end

  assign idOff      = addrQ[7:0];
  assign sect       = addrQ[SECT_LSB +: SECT_W];
  assign unusedAddr = ^addrQ;

  always_comb begin
    rdVal = '0;
    if (progBusy) begin
      rdVal[7] = !progBit7;
      rdVal[6] = togBit;
    end else if (strb.modeId) begin
      unique case (idOff)
        8'h00:   rdVal = MFR_CODE;
        8'h01:   rdVal = DEV_CODE;
        8'h02:   rdVal[0] = PROT_MAP[sect];
        default: rdVal = '0;
      endcase
    end else begin
      rdVal = mem[addrQ[MEM_AW-1:0]];
    end
  end

  assign dataOe  = rdAct && !strb.readBlock;
  assign dataOut = dataOe ? rdVal : '0;

endmodule

// File: rtl/flash_prog_engine.sv
module flash_prog_engine #(
  parameter int MEM_AW      = 6,
  parameter int DATA_W      = 16,
  parameter int PROG_CYCLES = 32
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              launch,
  input  logic              abort,
  input  logic [MEM_AW-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              busy,
  output logic              memWe,
  output logic [MEM_AW-1:0] memWaddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              bit7
);

  localparam int CNT_W = $clog2(PROG_CYCLES + 1);

  logic [CNT_W-1:0]  cnt;
  logic [MEM_AW-1:0] aLat;
  logic [DATA_W-1:0] dLat;

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      busy <= 1'b0;
      cnt  <= '0;
      aLat <= '0;
      dLat <= '0;
    end else if (abort) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch && !busy) begin
      busy <= 1'b1;
      cnt  <= CNT_W'(PROG_CYCLES);
      aLat <= reqAddr;
      dLat <= reqData;
    end else if (busy) begin
      if (cnt == CNT_W'(1)) busy <= 1'b0;
      cnt <= cnt - 1'b1;
    end
  end

  assign memWe    = busy && (cnt == CNT_W'(1)) && !abort;
  assign memWaddr = aLat;
  assign memWdata = dLat;
  assign bit7     = dLat[7];

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
  import flash_cmd_pkg::*;
#(
  parameter int ADDR_W      = 19,
  parameter int DATA_W      = 16,
  parameter int MEM_AW      = 6,
  parameter int SECT_LSB    = 12,
  parameter int SECT_W      = 7,
  parameter int PROG_CYCLES = 32,
  parameter int RST_HOLD    = 8,
  parameter int RD_DELAY    = 8,
  parameter logic [DATA_W-1:0] MFR_CODE = 16'h0052,
  parameter logic [DATA_W-1:0] DEV_CODE = 16'h3A91,
  parameter logic [(1<<SECT_W)-1:0] PROT_MAP = 'h5
) (
  input  logic              clk,
  input  logic              porN,
  input  logic              hwResetN,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              ready
);

  ctrlStrobe_t       strb;
  logic              wrDone, progBusy, progBit7, memWe;
  logic [ADDR_W-1:0] wrAddr;
  logic [DATA_W-1:0] wrData, memWdata;
  logic [MEM_AW-1:0] memWaddr;

  flash_cmd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RST_HOLD(RST_HOLD), .RD_DELAY(RD_DELAY)
  ) ctrl_i (
    .clk(clk), .porN(porN), .hwResetN(hwResetN), .wrDone(wrDone),
    .wrAddr(wrAddr), .wrData(wrData), .progBusy(progBusy), .strb(strb)
  );

  flash_cmd_dp #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_AW(MEM_AW), .SECT_LSB(SECT_LSB),
    .SECT_W(SECT_W), .MFR_CODE(MFR_CODE), .DEV_CODE(DEV_CODE), .PROT_MAP(PROT_MAP)
  ) dp_i (
    .clk(clk), .porN(porN), .ceN(ceN), .weN(weN), .oeN(oeN), .addr(addr),
    .dataIn(dataIn), .strb(strb), .progBusy(progBusy), .progBit7(progBit7),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata), .wrDone(wrDone),
    .wrAddr(wrAddr), .wrData(wrData), .dataOut(dataOut), .dataOe(dataOe)
  );

  flash_prog_engine #(
    .MEM_AW(MEM_AW), .DATA_W(DATA_W), .PROG_CYCLES(PROG_CYCLES)
  ) eng_i (
    .clk(clk), .porN(porN), .launch(strb.progLaunch), .abort(strb.abort),
    .reqAddr(wrAddr[MEM_AW-1:0]), .reqData(wrData), .busy(progBusy),
    .memWe(memWe), .memWaddr(memWaddr), .memWdata(memWdata), .bit7(progBit7)
  );

  assign ready = !progBusy && !strb.readBlock;

endmodule

// File: rtl/flash_cmd_chk.sv
module flash_cmd_chk (
  input logic clk,
  input logic porN,
  input logic launch,
  input logic abort,
  input logic modeId,
  input logic busy,
  input logic wrDone,
  input logic dataOe,
  input logic ready
);

  AST_LAUNCH_BUSY: assert property (@(posedge clk) disable iff (!porN)
    launch && !abort |=> busy);  // R7

  AST_READY_LOW_BUSY: assert property (@(posedge clk) disable iff (!porN)
    busy |-> !ready);  // R7

  AST_BUSY_HOLDS_MODE: assert property (@(posedge clk) disable iff (!porN)
    busy && !abort |=> $stable(modeId));  // R8

  AST_ABORT_ARRAY: assert property (@(posedge clk) disable iff (!porN)
    abort |=> !modeId && !busy);  // R11

  AST_ABORT_NO_READ: assert property (@(posedge clk) disable iff (!porN)
    abort |-> !dataOe);  // R11

  AST_ID_BY_WRITE: assert property (@(posedge clk) disable iff (!porN)
    $rose(modeId) |-> $past(wrDone));  // R3

endmodule

bind flash_cmd_if flash_cmd_chk chk_i (
  .clk(clk), .porN(porN), .launch(strb.progLaunch), .abort(strb.abort),
  .modeId(strb.modeId), .busy(progBusy), .wrDone(wrDone), .dataOe(dataOe),
  .ready(ready)
);

// File: tb/flash_cmd_if_tb_top.sv
module flash_cmd_if_tb_top;

  localparam int PROG = 60;
  localparam logic [15:0] MFR = 16'h0052;
  localparam logic [15:0] DEV = 16'h3A91;

  typedef struct {
    logic [15:0] d;
    logic        oe;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        porN = 1'b0;
  logic        hwResetN = 1'b1;
  logic        ceN = 1'b1, weN = 1'b1, oeN = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe, ready;

  int checks = 0;
  int fails = 0;
  exp_t expQ[$];
  event smp;

  always #4 clk = !clk;

  flash_cmd_if #(.PROG_CYCLES(PROG), .RST_HOLD(8), .RD_DELAY(8)) dut_i (
    .clk(clk), .porN(porN), .hwResetN(hwResetN), .ceN(ceN), .weN(weN),
    .oeN(oeN), .addr(addr), .dataIn(dataIn), .dataOut(dataOut),
    .dataOe(dataOe), .ready(ready)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops expected read results and compares
  initial begin
    forever begin
      exp_t it;
      @smp;
      it = expQ.pop_front();
      check({it.tag, " oe"}, {31'b0, dataOe}, {31'b0, it.oe});
      check({it.tag, " data"}, {16'b0, dataOut}, {16'b0, it.d});
    end
  end

  task automatic busRead(input logic [18:0] a, input logic [15:0] d, input logic oe, input string tag);
    exp_t it;
    @(negedge clk);
    addr = a; ceN = 0; oeN = 0;
    @(negedge clk);
    @(negedge clk);
    it.d = d; it.oe = oe; it.tag = tag;
    expQ.push_back(it);
    -> smp;
    #1;
    oeN = 1; ceN = 1;
    @(negedge clk);
  endtask

  task automatic busWrite(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; dataIn = d; ceN = 0; weN = 0;
    @(negedge clk);
    @(negedge clk);
    ceN = 1; weN = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  // chip enable falls first, write enable falls later; chip enable rises first
  task automatic orderedWrite(input logic [18:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = 19'h00010; dataIn = 16'h0000; ceN = 0;
    @(negedge clk);
    addr = a; weN = 0;
    @(negedge clk);
    addr = 19'h00010; dataIn = d;
    @(negedge clk);
    ceN = 1;
    @(negedge clk);
    dataIn = 16'h0000;
    @(negedge clk);
    weN = 1;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic unlock(input logic [7:0] cmd);
    busWrite(19'h00555, 16'h00AA);
    busWrite(19'h002AA, 16'h0055);
    busWrite(19'h00555, {8'h00, cmd});
  endtask

  task automatic waitReady();
    for (int i = 0; i < 200; i++) begin
      if (ready) break;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 ready after reset", {31'b0, ready}, 32'd1);
    check("R12 idle dataOe", {31'b0, dataOe}, 32'd0);
    busRead(19'h00005, 16'hFFFF, 1, "R1 erased read");
    busWrite(19'h00003, 16'h0000);
    busRead(19'h00003, 16'hFFFF, 1, "R1 stray write ignored");

    // R12 output enable without chip enable
    @(negedge clk); oeN = 0; ceN = 1;
    @(negedge clk); @(negedge clk);
    check("R12 no ce no drive", {15'b0, dataOe, dataOut}, 32'd0);
    oeN = 1;

    // R3 identifier mode
    unlock(8'h90);
    busRead(19'h00000, MFR, 1, "R3 manufacturer code");
    busRead(19'h00001, DEV, 1, "R3 device code");
    busRead(19'h00002, 16'h0001, 1, "R4 sector0 protected");
    busRead(19'h01002, 16'h0000, 1, "R4 sector1 unprotected");
    busRead(19'h02002, 16'h0001, 1, "R4 sector2 protected");
    busRead(19'h00007, 16'h0000, 1, "R4 other offset");
    busRead(19'h00000, MFR, 1, "R2 mode persists");

    // R11 short pulse has no effect
    @(negedge clk); hwResetN = 0;
    repeat (3) @(negedge clk);
    hwResetN = 1;
    busRead(19'h00001, DEV, 1, "R11 short pulse ignored");

    // R9 bad unlock
    busWrite(19'h00555, 16'h00AA);
    busWrite(19'h002AB, 16'h0055);
    busWrite(19'h00555, 16'h00F0);
    busRead(19'h00000, MFR, 1, "R9 bad unlock address keeps mode");
    busWrite(19'h00555, 16'h00AB);
    busWrite(19'h002AA, 16'h0055);
    busWrite(19'h00555, 16'h00F0);
    busRead(19'h00000, MFR, 1, "R9 bad unlock data keeps mode");

    // R5 back to array
    unlock(8'hF0);
    busRead(19'h00000, 16'hFFFF, 1, "R5 array mode after reset command");

    // R6 R10 program with skewed strobes
    unlock(8'hA0);
    orderedWrite(19'h00007, 16'h1234);
    check("R7 ready low while programming", {31'b0, ready}, 32'd0);
    busRead(19'h00007, 16'h00C0, 1, "R7 status first read");
    busRead(19'h00007, 16'h0080, 1, "R7 status second read");
    unlock(8'h90);  // R8 ignored while busy
    waitReady();
    check("R7 ready after program", {31'b0, ready}, 32'd1);
    busRead(19'h00007, 16'h1234, 1, "R6 programmed word");
    busRead(19'h00010, 16'hFFFF, 1, "R10 stray address untouched");
    busRead(19'h00000, 16'hFFFF, 1, "R8 command during busy ignored");

    // R6 bits only clear
    unlock(8'hA0);
    busWrite(19'h00007, 16'hFF80);
    waitReady();
    busRead(19'h00007, 16'h1200, 1, "R6 and-merge");

    // R11 long reset aborts program and identifier mode
    unlock(8'h90);
    unlock(8'hA0);
    busWrite(19'h00009, 16'h0000);
    @(negedge clk); hwResetN = 0;
    repeat (12) @(negedge clk);
    check("R11 ready low in reset", {31'b0, ready}, 32'd0);
    hwResetN = 1;
    busRead(19'h00009, 16'h0000, 0, "R11 read blocked after release");
    repeat (20) @(negedge clk);
    check("R11 ready after delay", {31'b0, ready}, 32'd1);
    busRead(19'h00009, 16'hFFFF, 1, "R11 program aborted");
    busRead(19'h00000, 16'hFFFF, 1, "R11 array mode after reset");

    repeat (4) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule